// File: doc/BRIEF.md
# Speculative Register Shadow Overlay

This block holds an integer register file together with a second, shadow copy of every register and a one-bit-per-register map that says which copy is current. While the machine runs down a path that follows a mispredicted branch, results are written only into the shadow copy. The architectural values stay intact. Reads pick between the two copies per register by looking up the map.

The block enters speculative mode by itself when a decoded instruction's predicted next PC differs from its computed next PC, provided fetch has not already been steered to the correct path. At that moment it saves the computed next PC. When the branch resolves, a single recovery pulse clears the whole map in one cycle and leaves speculative mode. For one cycle after that, the block presents the saved PC so that fetch can restart there. The shadow data itself is not erased. It simply becomes invisible.

The block has two combinational read ports and one write port. A write becomes visible to reads from the next cycle onward. There is no bypass from the write port to the read ports.

Top module: `spec_shadow_rf`

## Requirements
- R1: Outside speculative mode, a write with `wr_en_i` high stores `wr_data_i` into architectural register `wr_idx_i`. Both read ports return the new value from the cycle after the write edge.
- R2: In speculative mode, a write goes to the shadow copy and leaves the architectural register unchanged. After recovery, the register reads back its pre-speculation value.
- R3: A read returns the shadow value if the register's map bit was set by a speculative write, and the architectural value otherwise. Each register is selected independently on each port.
- R4: Speculative mode (`spec_mode_o`=1) begins at the edge where `dec_valid_i`=1, `pred_npc_i`!=`calc_npc_i` and `fetch_redir_i`=0. If any one of these conditions is false, the mode does not change.
- R5: `recover_i` in speculative mode clears the entire map and drops `spec_mode_o` at the next edge. From then on, every register reads its architectural value, including registers whose shadow data was left in place.
- R6: The cycle after recovery, `restart_valid_o` is high for exactly one cycle, and `restart_pc_o` equals the `calc_npc_i` captured at mode entry. `recover_i` outside speculative mode has no effect.
- R7: An entry request while already speculative is ignored. The saved restart PC keeps the value from the first entry.
- R8: A read of a register in the same cycle as a write to it returns the value held before that write.
- R9: After reset, `spec_mode_o`=0, `restart_valid_o`=0, and every register reads 0 on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | IW | Read port A register index |
| rd_a_data_o | output | DW | Read port A data |
| rd_b_idx_i | input | IW | Read port B register index |
| rd_b_data_o | output | DW | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | IW | Write register index |
| wr_data_i | input | DW | Write data |
| dec_valid_i | input | 1 | A decoded instruction is presented |
| pred_npc_i | input | PCW | Predicted next PC of that instruction |
| calc_npc_i | input | PCW | Computed next PC of that instruction |
| fetch_redir_i | input | 1 | Fetch was already redirected for it |
| recover_i | input | 1 | Mispredicted branch resolved; discard speculation |
| spec_mode_o | output | 1 | Speculative mode active |
| restart_valid_o | output | 1 | One-cycle restart request |
| restart_pc_o | output | PCW | Saved restart PC |

## Verification
Every register is written outside speculation with a distinct value and read back on both ports. Then only the even registers are overwritten speculatively. This interleaved pattern shows whether the read steering works per register rather than per mode. The second port sweeps in reverse order, which separates the two ports' index paths.

Entry is probed with each of its three conditions false in turn, and with a second request that carries a different PC. Recovery is tried both inside and outside speculative mode. A write that coincides with a read of the same register is sampled before the edge to confirm the old value comes back. A second episode after recovery shows that stale shadow data stays hidden.

// File: rtl/spec_shadow_pkg.sv
package spec_shadow_pkg;

  typedef enum logic {
    MODE_ARCH = 1'b0,
    MODE_SPEC = 1'b1
  } mode_e;

  // decision to start running down a wrong path
  function automatic logic enter_ok(input logic dec_valid,
                                    input logic npc_differs,
                                    input logic redirected,
                                    input logic in_spec);
    return dec_valid && npc_differs && !redirected && !in_spec;
  endfunction

  // copy selection for a read: shadow when the map bit is set
  function automatic logic use_shadow(input logic map_bit);
    return map_bit;
  endfunction

endpackage

// File: rtl/srf_bank.sv
module srf_bank #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ra_idx_i,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o
);

  logic [DW-1:0] cell_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    logic hit;
    assign hit = we_i && (widx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  cell_q[g] <= '0;
      else if (hit) cell_q[g] <= wdata_i;
    end
  end

  assign ra_data_o = cell_q[ra_idx_i];
  assign rb_data_o = cell_q[rb_idx_i];

endmodule

// File: rtl/srf_valid_map.sv
module srf_valid_map #(
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [IW-1:0]   set_idx_i,
  input  logic            clear_i,
  output logic [NREG-1:0] map_o
);

  logic [NREG-1:0] map_q;
  logic [NREG-1:0] set_vec;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign set_vec[g] = set_i && (set_idx_i == IW'(g));
  end

  // clear wins over a set in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      map_q <= '0;
    else if (clear_i) map_q <= '0;
    else              map_q <= map_q | set_vec;
  end

  assign map_o = map_q;

endmodule

// File: rtl/srf_mode_ctl.sv
module srf_mode_ctl
  import spec_shadow_pkg::*;
#(
  parameter int PCW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dec_valid_i,
  input  logic [PCW-1:0] pred_npc_i,
  input  logic [PCW-1:0] calc_npc_i,
  input  logic           fetch_redir_i,
  input  logic           recover_i,
  output logic           spec_o,
  output logic           enter_evt_o,
  output logic           exit_evt_o,
  output logic           restart_valid_o,
  output logic [PCW-1:0] restart_pc_o
);

  mode_e          mode_q;
  logic [PCW-1:0] rpc_q;
  logic           rvalid_q;
  logic           in_spec;

  assign in_spec     = (mode_q == MODE_SPEC);
  assign enter_evt_o = enter_ok(dec_valid_i, pred_npc_i != calc_npc_i,
                                fetch_redir_i, in_spec);
  assign exit_evt_o  = recover_i && in_spec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_ARCH;
      rpc_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= exit_evt_o;
      if (exit_evt_o) begin
        mode_q <= MODE_ARCH;
      end else if (enter_evt_o) begin
        mode_q <= MODE_SPEC;
        rpc_q  <= calc_npc_i;
      end
    end
  end

  assign spec_o          = in_spec;
  assign restart_valid_o = rvalid_q;
  assign restart_pc_o    = rpc_q;

endmodule

// File: rtl/spec_shadow_rf.sv
module spec_shadow_rf
  import spec_shadow_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 16,
  parameter int PCW  = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [IW-1:0]  rd_a_idx_i,
  output logic [DW-1:0]  rd_a_data_o,
  input  logic [IW-1:0]  rd_b_idx_i,
  output logic [DW-1:0]  rd_b_data_o,
  input  logic           wr_en_i,
  input  logic [IW-1:0]  wr_idx_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic           dec_valid_i,
  input  logic [PCW-1:0] pred_npc_i,
  input  logic [PCW-1:0] calc_npc_i,
  input  logic           fetch_redir_i,
  input  logic           recover_i,
  output logic           spec_mode_o,
  output logic           restart_valid_o,
  output logic [PCW-1:0] restart_pc_o
);

  // internal events, named for the checker
  logic            arch_we;
  logic            shad_we;
  logic            enter_evt;
  logic            exit_evt;
  logic [NREG-1:0] valid_map;
  logic [DW-1:0]   arch_a, arch_b, shad_a, shad_b;

  srf_mode_ctl #(.PCW(PCW)) u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .dec_valid_i    (dec_valid_i),
    .pred_npc_i     (pred_npc_i),
    .calc_npc_i     (calc_npc_i),
    .fetch_redir_i  (fetch_redir_i),
    .recover_i      (recover_i),
    .spec_o         (spec_mode_o),
    .enter_evt_o    (enter_evt),
    .exit_evt_o     (exit_evt),
    .restart_valid_o(restart_valid_o),
    .restart_pc_o   (restart_pc_o)
  );

  assign arch_we = wr_en_i && !spec_mode_o;
  assign shad_we = wr_en_i &&  spec_mode_o;

  srf_bank #(.NREG(NREG), .DW(DW)) u_arch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (arch_we),
    .widx_i   (wr_idx_i),
    .wdata_i  (wr_data_i),
    .ra_idx_i (rd_a_idx_i),
    .rb_idx_i (rd_b_idx_i),
    .ra_data_o(arch_a),
    .rb_data_o(arch_b)
  );

  srf_bank #(.NREG(NREG), .DW(DW)) u_shadow (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (shad_we),
    .widx_i   (wr_idx_i),
    .wdata_i  (wr_data_i),
    .ra_idx_i (rd_a_idx_i),
    .rb_idx_i (rd_b_idx_i),
    .ra_data_o(shad_a),
    .rb_data_o(shad_b)
  );

  srf_valid_map #(.NREG(NREG)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (shad_we),
    .set_idx_i(wr_idx_i),
    .clear_i  (exit_evt),
    .map_o    (valid_map)
  );

  assign rd_a_data_o = use_shadow(valid_map[rd_a_idx_i]) ? shad_a : arch_a;
  assign rd_b_data_o = use_shadow(valid_map[rd_b_idx_i]) ? shad_b : arch_b;

endmodule

// File: rtl/spec_shadow_rf_chk.sv
module spec_shadow_rf_chk #(
  parameter int NREG = 8,
  parameter int PCW  = 16,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic [IW-1:0]   wr_idx_i,
  input logic            dec_valid_i,
  input logic [PCW-1:0]  pred_npc_i,
  input logic [PCW-1:0]  calc_npc_i,
  input logic            fetch_redir_i,
  input logic            recover_i,
  input logic            spec_mode_o,
  input logic            restart_valid_o,
  input logic [PCW-1:0]  restart_pc_o,
  input logic            arch_we,
  input logic [NREG-1:0] valid_map
);

  p_arch_untouched_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_mode_o |-> !arch_we);

  p_map_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_mode_o && wr_en_i && !recover_i) |=> valid_map[$past(wr_idx_i)]);

  p_enter_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spec_mode_o && dec_valid_i && (pred_npc_i != calc_npc_i) && !fetch_redir_i)
      |=> spec_mode_o);

  p_exit_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spec_mode_o && recover_i) |=> (!spec_mode_o && valid_map == '0));

  p_map_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spec_mode_o |-> (valid_map == '0));

  p_restart_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_valid_o |-> $past(spec_mode_o && recover_i));

  p_pc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spec_mode_o |=> $stable(restart_pc_o));

endmodule

bind spec_shadow_rf spec_shadow_rf_chk #(.NREG(NREG), .PCW(PCW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_idx_i       (wr_idx_i),
  .dec_valid_i    (dec_valid_i),
  .pred_npc_i     (pred_npc_i),
  .calc_npc_i     (calc_npc_i),
  .fetch_redir_i  (fetch_redir_i),
  .recover_i      (recover_i),
  .spec_mode_o    (spec_mode_o),
  .restart_valid_o(restart_valid_o),
  .restart_pc_o   (restart_pc_o),
  .arch_we        (arch_we),
  .valid_map      (valid_map)
);

// File: tb/test_spec_shadow_rf.sv
module test_spec_shadow_rf;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int PCW  = 16;
  localparam int IW   = $clog2(NREG);

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [IW-1:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [DW-1:0]  rd_a_data_o, rd_b_data_o, wr_data_i = '0;
  logic           wr_en_i = 1'b0, dec_valid_i = 1'b0, fetch_redir_i = 1'b0, recover_i = 1'b0;
  logic [PCW-1:0] pred_npc_i = '0, calc_npc_i = '0, restart_pc_o;
  logic           spec_mode_o, restart_valid_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  spec_shadow_rf #(.NREG(NREG), .DW(DW), .PCW(PCW)) i_spec_shadow_rf (.*);

  function automatic logic [DW-1:0] arch_val(int i);
    return DW'(16'hA000 + i * 37);
  endfunction
  function automatic logic [DW-1:0] spec_val(int i);
    return DW'(16'h5000 ^ (i * 101));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // advance to 5 ns after the next rising edge
  task automatic tick();
    @(posedge clk_i);
    #5;
  endtask

  task automatic write(int idx, logic [DW-1:0] d);
    wr_en_i = 1'b1; wr_idx_i = IW'(idx); wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic read_all(string tag, bit spec_even);
    for (int i = 0; i < NREG; i++) begin
      int j;
      logic [DW-1:0] ea, eb;
      j = NREG - 1 - i;
      rd_a_idx_i = IW'(i); rd_b_idx_i = IW'(j);
      #1;
      ea = (spec_even && (i % 2 == 0)) ? spec_val(i) : arch_val(i);
      eb = (spec_even && (j % 2 == 0)) ? spec_val(j) : arch_val(j);
      chk(rd_a_data_o == ea, tag, rd_a_data_o, ea);
      chk(rd_b_data_o == eb, tag, rd_b_data_o, eb);
    end
  endtask

  task automatic decode(logic [PCW-1:0] p, logic [PCW-1:0] c, bit redir);
    dec_valid_i = 1'b1; pred_npc_i = p; calc_npc_i = c; fetch_redir_i = redir;
    tick();
    dec_valid_i = 1'b0; fetch_redir_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #3 rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    // R9 reset state
    chk(spec_mode_o == 1'b0, "R9 spec_mode after reset", spec_mode_o, 0);
    chk(restart_valid_o == 1'b0, "R9 restart_valid after reset", restart_valid_o, 0);
    for (int i = 0; i < NREG; i++) begin
      rd_a_idx_i = IW'(i); rd_b_idx_i = IW'(i); #1;
      chk(rd_a_data_o == '0 && rd_b_data_o == '0, "R9 register zero after reset", rd_a_data_o, 0);
    end

    // R1 architectural writes
    for (int i = 0; i < NREG; i++) write(i, arch_val(i));
    read_all("R1 architectural readback", 1'b0);

    // R6 recovery outside speculation has no effect
    recover_i = 1'b1; tick(); recover_i = 1'b0; #1;
    chk(restart_valid_o == 1'b0, "R6 recover ignored when not speculative", restart_valid_o, 0);

    // R4 entry conditions
    decode(16'h0100, 16'h0100, 1'b0); #1;
    chk(spec_mode_o == 1'b0, "R4 equal PCs do not enter", spec_mode_o, 0);
    decode(16'h0100, 16'h0200, 1'b1); #1;
    chk(spec_mode_o == 1'b0, "R4 redirected fetch does not enter", spec_mode_o, 0);
    dec_valid_i = 1'b0; pred_npc_i = 16'h0100; calc_npc_i = 16'h0300; tick(); #1;
    chk(spec_mode_o == 1'b0, "R4 no decode does not enter", spec_mode_o, 0);
    decode(16'h0104, 16'h0400, 1'b0); #1;
    chk(spec_mode_o == 1'b1, "R4 mismatch enters speculation", spec_mode_o, 1);

    // R7 second entry ignored
    decode(16'h0500, 16'h0600, 1'b0); #1;
    chk(spec_mode_o == 1'b1, "R7 still speculative", spec_mode_o, 1);
    chk(restart_pc_o == 16'h0400, "R7 restart PC kept", restart_pc_o, 16'h0400);

    // R2 / R3 speculative writes to even registers
    for (int i = 0; i < NREG; i += 2) write(i, spec_val(i));
    read_all("R3 per-register steering", 1'b1);

    // R8 same-cycle read and write of register 1
    wr_en_i = 1'b1; wr_idx_i = IW'(1); wr_data_i = 16'hBEEF;
    rd_a_idx_i = IW'(1); #1;
    chk(rd_a_data_o == arch_val(1), "R8 old value during write", rd_a_data_o, arch_val(1));
    tick(); wr_en_i = 1'b0; #1;
    chk(rd_a_data_o == 16'hBEEF, "R3 speculative write visible next cycle", rd_a_data_o, 16'hBEEF);

    // R5 / R6 recovery
    recover_i = 1'b1; tick(); recover_i = 1'b0; #1;
    chk(spec_mode_o == 1'b0, "R5 speculation left", spec_mode_o, 0);
    chk(restart_valid_o == 1'b1, "R6 restart pulse", restart_valid_o, 1);
    chk(restart_pc_o == 16'h0400, "R6 restart PC", restart_pc_o, 16'h0400);
    read_all("R2 R5 architectural values restored", 1'b0);
    tick(); #1;
    chk(restart_valid_o == 1'b0, "R6 pulse is one cycle", restart_valid_o, 0);

    // R5 stale shadow data stays hidden in a new episode
    decode(16'h0010, 16'h0020, 1'b0); #1;
    chk(spec_mode_o == 1'b1, "R4 second episode entered", spec_mode_o, 1);
    write(3, 16'h1234);
    rd_a_idx_i = IW'(2); rd_b_idx_i = IW'(3); #1;
    chk(rd_a_data_o == arch_val(2), "R5 old shadow of reg 2 hidden", rd_a_data_o, arch_val(2));
    chk(rd_b_data_o == 16'h1234, "R3 new shadow of reg 3", rd_b_data_o, 16'h1234);
    recover_i = 1'b1; tick(); recover_i = 1'b0; #1;
    chk(restart_pc_o == 16'h0020, "R6 second restart PC", restart_pc_o, 16'h0020);
    rd_b_idx_i = IW'(3); #1;
    chk(rd_b_data_o == arch_val(3), "R2 reg 3 architectural kept", rd_b_data_o, arch_val(3));

    // R1 architectural write after recovery
    write(5, 16'h7777);
    rd_a_idx_i = IW'(5); #1;
    chk(rd_a_data_o == 16'h7777, "R1 write after recovery", rd_a_data_o, 16'h7777);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule